// File: doc/BRIEF.md
# Background Gain Calibration Engine for the First Pipeline Stage

This block tracks the digital gain coefficient of the first stage of a pipelined converter while normal conversions go on. Each valid sample is tagged with one bit from a pseudo-random sequence. The bit drives a fixed-size injection into the first-stage residue path. Because the injection has an analog amplitude of a quarter of the reference, it passes through the same interstage gain as the signal.

The block receives the residue-path word for each sample and scales it by the current coefficient. It then removes the injected component, using its ideal digital size of plus or minus `TEST_AMP` selected by the test bit, and presents the result downstream. The cleaned word is multiplied by the test sign (±1) and summed over a programmable block of samples. The sum is proportional to the amplitude times `(1 - G*l)`, where G is the true path gain and l is the coefficient, so it is zero only when l equals 1/G.

At the end of each block the sum, shifted right by a programmable amount, is subtracted from the coefficient. The sum is then cleared and a one-cycle done pulse is issued. Over many blocks the coefficient settles at the inverse of the analog path gain.

Top module: `gain_cal_engine`

## Requirements
- R1: While reset is high and in the cycle after it, `coef_out` equals unity, which is 2^14 with 14 fractional bits. `test_bit` equals bit 22 of the seed 23'h5A3C1F, and `out_valid` and `block_done` are 0.
- R2: The test sequence is a 23-bit Fibonacci LFSR with polynomial x^23+x^18+1. The new bit 0 is the XOR of bit 22 and bit 17, and the register shifts toward the MSB. `test_bit` is bit 22 of the state. The state advances once per accepted sample and holds when `in_valid` is low. Bit value 1 means +1 and 0 means -1.
- R3: A sample accepted at edge k appears on `out_data` with `out_valid` high after edge k+2. The value is floor(`in_data`·coef / 2^14) minus (+8192 if its test bit was 1, else -8192). The coef used is the value held at edge k, and the test bit is the `test_bit` value at edge k.
- R4: An `out_data` result beyond the signed 16-bit range saturates to 32767 or -32768.
- R5: Every output sample adds (+`out_data` if its test bit is 1, else -`out_data`) to a 48-bit sum. When the sample count reaches `cfg_block_len`, `block_done` goes high for one cycle, one edge after that sample's `out_valid`. The sum and count then restart from zero.
- R6: At block end the coefficient becomes coef - (sum >>> `cfg_step_shift`), arithmetic shift, with the result clamped to [0, 2^18-1]. The coefficient changes at no other time.
- R7: A `cfg_block_len` of 0 behaves as 1, so every output sample ends a block.
- R8: When the residue word carries the signal plus the ±8192 injection scaled by a path gain of 115/128, the coefficient settles within ±400 of 18236 (16384·128/115) after 24 blocks of 4096 samples with shift 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_block_len | input | 24 | Samples per correlation block (0 acts as 1) |
| cfg_step_shift | input | 6 | Right shift applied to the block sum before the update |
| in_valid | input | 1 | Residue-path sample present |
| in_data | input | 16 | Signed residue-path word |
| test_bit | output | 1 | Current test-sequence bit to the injection |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | 16 | Signed scaled word with the test component removed |
| coef_out | output | 18 | Gain coefficient, unsigned, 14 fractional bits |
| block_done | output | 1 | One-cycle pulse when a block ends and the coefficient updates |

## Verification
The assertions assume that `cfg_block_len` and `cfg_step_shift` do not change during operation and are altered only while reset is high. The count-bound property would fail if the length shrank in the middle of a block. The stimulus sets every configuration under reset before each run.

The stimulus covers:
- sparse and dense valid patterns;
- full-scale words that force saturation;
- a zero block length with shift 0, so the coefficient hits both clamp limits;
- a behavioural gain-error stage whose test bit comes from the bench's own sequence, for the convergence check.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
  localparam int SEQ_W   = 23;
  localparam int SEQ_TAP = 18;
  localparam logic [SEQ_W-1:0] SEQ_SEED = 23'h5A3C1F;

  function automatic logic [SEQ_W-1:0] seq_step(input logic [SEQ_W-1:0] s);
    return {s[SEQ_W-2:0], s[SEQ_W-1] ^ s[SEQ_TAP-1]};
  endfunction
endpackage

// File: rtl/gcal_prbs.sv
module gcal_prbs
  import gcal_pkg::*;
#(
  parameter logic [SEQ_W-1:0] SEED = SEQ_SEED
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic bit_o
);
  logic [SEQ_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else if (adv_i) state_q <= seq_step(state_q);
  end

  assign bit_o = state_q[SEQ_W-1];

  // R2: the sequence only moves on accepted samples
  assert_seq_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(state_q)) else $error("sequence moved without a sample");
  // R2: a maximal-length register never falls into the all-zero state
  assert_seq_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    state_q != '0) else $error("sequence locked at zero");
endmodule

// File: rtl/gcal_scale_path.sv
module gcal_scale_path #(
  parameter int DW       = 16,
  parameter int CW       = 18,
  parameter int FB       = 14,
  parameter int TEST_AMP = 8192
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] data_i,
  input  logic                 tbit_i,
  input  logic [CW-1:0]        coef_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] data_o,
  output logic                 tbit_o
);
  localparam int PW   = DW + CW + 1;
  localparam int MAXI = (1 << (DW-1)) - 1;
  localparam int MINI = -(1 << (DW-1));
  localparam logic signed [PW:0] AMP_P = (PW+1)'(TEST_AMP);
  localparam logic signed [PW:0] MAX_P = (PW+1)'(MAXI);
  localparam logic signed [PW:0] MIN_P = (PW+1)'(MINI);

  logic signed [PW-1:0] data_ext, coef_ext, prod_q, scaled;
  logic                 v1_q, t1_q;
  logic signed [PW:0]   diff;

  assign data_ext = {{(PW-DW){data_i[DW-1]}}, data_i};
  assign coef_ext = {{(PW-CW){1'b0}}, coef_i};

  // first register: product with the coefficient in force at this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      v1_q   <= 1'b0;
      t1_q   <= 1'b0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        prod_q <= data_ext * coef_ext;
        t1_q   <= tbit_i;
      end
    end
  end

  assign scaled = prod_q >>> FB;
  assign diff   = {scaled[PW-1], scaled} - (t1_q ? AMP_P : -AMP_P);

  // second register: test removal and saturation
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      tbit_o  <= 1'b0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) begin
        tbit_o <= t1_q;
        if (diff > MAX_P)      data_o <= MAX_P[DW-1:0];
        else if (diff < MIN_P) data_o <= MIN_P[DW-1:0];
        else                   data_o <= diff[DW-1:0];
      end
    end
  end

  // R3: output sample follows an accepted sample by two edges
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(valid_i, 2)) else $error("output without matching input");
endmodule

// File: rtl/gcal_correlator.sv
module gcal_correlator #(
  parameter int DW = 16,
  parameter int LW = 24,
  parameter int AW = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] data_i,
  input  logic                 tbit_i,
  input  logic [LW-1:0]        len_i,
  output logic                 last_o,
  output logic signed [AW-1:0] sum_o,
  output logic                 done_o
);
  logic signed [AW-1:0] acc_q, term;
  logic [LW-1:0]        cnt_q;

  assign term   = tbit_i ? {{(AW-DW){data_i[DW-1]}}, data_i}
                         : -{{(AW-DW){data_i[DW-1]}}, data_i};
  assign sum_o  = acc_q + term;
  assign last_o = valid_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, len_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (last_o) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (valid_i) begin
        acc_q <= sum_o;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5: the count never passes the block length (R7: zero length keeps it at zero)
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (len_i == '0) ? (cnt_q == '0) : (cnt_q < len_i)) else $error("block count overran");
endmodule

// File: rtl/gcal_coef_loop.sv
module gcal_coef_loop #(
  parameter int CW = 18,
  parameter int FB = 14,
  parameter int AW = 48,
  parameter int SW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_i,
  input  logic signed [AW-1:0] sum_i,
  input  logic [SW-1:0]        shift_i,
  output logic [CW-1:0]        coef_o
);
  localparam logic [CW-1:0] UNITY = CW'(1 << FB);
  localparam logic signed [AW+1:0] CMAX = (AW+2)'((1 << CW) - 1);

  logic signed [AW-1:0] delta;
  logic signed [AW+1:0] cand;

  assign delta = sum_i >>> shift_i;
  assign cand  = $signed({{(AW+2-CW){1'b0}}, coef_o})
               - $signed({{2{delta[AW-1]}}, delta});

  always_ff @(posedge clk) begin
    if (rst) coef_o <= UNITY;
    else if (upd_i) begin
      if (cand < 0)         coef_o <= '0;
      else if (cand > CMAX) coef_o <= CMAX[CW-1:0];
      else                  coef_o <= cand[CW-1:0];
    end
  end
endmodule

// File: rtl/gain_cal_engine.sv
module gain_cal_engine
  import gcal_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 18,
  parameter int FB       = 14,
  parameter int LW       = 24,
  parameter int AW       = 48,
  parameter int SW       = 6,
  parameter int TEST_AMP = 1 << (DW-3)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LW-1:0]        cfg_block_len,
  input  logic [SW-1:0]        cfg_step_shift,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 test_bit,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic [CW-1:0]        coef_out,
  output logic                 block_done
);
  logic                 pipe_tbit, blk_last;
  logic signed [AW-1:0] blk_sum;

  gcal_prbs #(.SEED(SEQ_SEED)) i_prbs (
    .clk(clk), .rst(rst), .adv_i(in_valid), .bit_o(test_bit));

  gcal_scale_path #(.DW(DW), .CW(CW), .FB(FB), .TEST_AMP(TEST_AMP)) i_scale (
    .clk(clk), .rst(rst), .valid_i(in_valid), .data_i(in_data), .tbit_i(test_bit),
    .coef_i(coef_out), .valid_o(out_valid), .data_o(out_data), .tbit_o(pipe_tbit));

  gcal_correlator #(.DW(DW), .LW(LW), .AW(AW)) i_corr (
    .clk(clk), .rst(rst), .valid_i(out_valid), .data_i(out_data), .tbit_i(pipe_tbit),
    .len_i(cfg_block_len), .last_o(blk_last), .sum_o(blk_sum), .done_o(block_done));

  gcal_coef_loop #(.CW(CW), .FB(FB), .AW(AW), .SW(SW)) i_coef (
    .clk(clk), .rst(rst), .upd_i(blk_last), .sum_i(blk_sum),
    .shift_i(cfg_step_shift), .coef_o(coef_out));

  // R5: a block can only end on a delivered sample
  assert_done_after_sample_R5: assert property (@(posedge clk) disable iff (rst)
    block_done |-> $past(out_valid)) else $error("done without a sample");
  // R6: the coefficient moves only together with a block end
  assert_coef_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !block_done |-> $stable(coef_out)) else $error("coefficient moved between blocks");
endmodule

// File: tb/test_gain_cal_engine.sv
module test_gain_cal_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [22:0] SEED = 23'h5A3C1F;
  localparam longint UNITY = 16384;
  localparam longint AMP = 8192;

  logic clk = 0, rst = 1;
  logic [23:0] cfg_block_len = 24'd8;
  logic [5:0]  cfg_step_shift = 6'd4;
  logic        in_valid = 0;
  logic signed [15:0] in_data = 0;
  logic test_bit, out_valid, block_done;
  logic signed [15:0] out_data;
  logic [17:0] coef_out;

  gain_cal_engine i_gain_cal_engine (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit cmp_on = 0, finished = 0;
  int n_done = 0, n_out = 0;
  logic [31:0] lcg = 32'h1234_5678;

  // behavioural reference state
  logic [22:0] m_seq;
  bit m_v1, m_t1, m_v2, m_t2, m_done, m_sat;
  longint m_prod, m_out, m_acc, m_coef, m_cnt;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] rnd16();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[30:15];
  endfunction

  always @(posedge clk) begin
    longint n_prod, n_out, v, term, accn, cand, len;
    bit n_t1, n_sat;
    if (rst) begin
      m_seq = SEED; m_v1 = 0; m_t1 = 0; m_v2 = 0; m_t2 = 0; m_done = 0; m_sat = 0;
      m_prod = 0; m_out = 0; m_acc = 0; m_coef = UNITY; m_cnt = 0;
    end else begin
      n_prod = m_prod; n_t1 = m_t1;
      if (in_valid) begin n_prod = longint'(in_data) * m_coef; n_t1 = m_seq[22]; end
      n_out = m_out; n_sat = m_sat;
      if (m_v1) begin
        v = (m_prod >>> 14) - (m_t1 ? AMP : -AMP);
        n_sat = (v > 32767) || (v < -32768);
        n_out = (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
      end
      m_done = 0;
      if (m_v2) begin
        term = m_t2 ? m_out : -m_out;
        accn = m_acc + term;
        len = longint'(cfg_block_len);
        if (m_cnt + 1 >= len) begin
          cand = m_coef - (accn >>> cfg_step_shift);
          m_coef = (cand < 0) ? 0 : (cand > 262143) ? 262143 : cand;
          m_acc = 0; m_cnt = 0; m_done = 1;
        end else begin
          m_acc = accn; m_cnt = m_cnt + 1;
        end
      end
      if (m_v1) m_t2 = m_t1;
      m_v2 = m_v1; m_out = n_out; m_sat = n_sat;
      m_v1 = in_valid; m_prod = n_prod; m_t1 = n_t1;
      if (in_valid) m_seq = {m_seq[21:0], m_seq[22] ^ m_seq[17]};
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(test_bit == m_seq[22], "R2 test_bit", test_bit, m_seq[22]);
      chk(out_valid == m_v2, "R3 out_valid", out_valid, m_v2);
      if (m_v2) chk(longint'(out_data) == m_out, m_sat ? "R4 saturated out_data" : "R3 out_data",
                    out_data, m_out);
      chk(block_done == m_done, "R5 block_done", block_done, m_done);
      chk(longint'(coef_out) == m_coef, "R6 coef_out", coef_out, m_coef);
      if (block_done) n_done++;
      if (out_valid) n_out++;
    end
  end

  task automatic do_reset(logic [23:0] len, logic [5:0] sh);
    @(negedge clk);
    rst = 1; in_valid = 0; cfg_block_len = len; cfg_step_shift = sh;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    int pos_ok, neg_ok;
    cmp_on = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(coef_out == 18'd16384, "R1 coef reset", coef_out, 16384);
    chk(test_bit == SEED[22], "R1 test_bit reset", test_bit, SEED[22]);
    chk(!out_valid && !block_done, "R1 out_valid/block_done reset", {out_valid, block_done}, 0);
    rst = 0;
    @(negedge clk);
    chk(coef_out == 18'd16384, "R1 coef after reset", coef_out, 16384);
    cmp_on = 1;

    // run A: short blocks, mixed valid pattern, full-range data with saturation
    for (int i = 0; i < 800; i++) begin
      logic [15:0] r = rnd16();
      in_valid = (r[1:0] != 2'b00) || (i > 600);
      in_data = (i % 37 == 0) ? 16'sh7FFF : (i % 41 == 0) ? -16'sh8000 : $signed(rnd16());
      @(negedge clk);
    end
    in_valid = 0;
    repeat (4) @(negedge clk);

    // run B: R7 zero length, shift 0, coefficient driven to its clamps (R6)
    do_reset(24'd0, 6'd0);
    n_done = 0; n_out = 0;
    for (int i = 0; i < 300; i++) begin
      in_valid = i[0] | i[2];
      in_data = (i < 150) ? 16'sh7FFF : -16'sh8000;
      @(negedge clk);
    end
    in_valid = 0;
    repeat (4) @(negedge clk);
    chk(n_done == n_out, "R7 one done per sample at zero length", n_done, n_out);

    // run C: R8 convergence with a gain-error stage model (gain 115/128)
    do_reset(24'd4096, 6'd13);
    for (int i = 0; i < 24*4096 + 8; i++) begin
      int x, t;
      x = int'(rnd16() % 16'd4096) - 2048;
      t = m_seq[22] ? 8192 : -8192;
      in_valid = 1;
      in_data = 16'((x + t) * 115 >>> 7);
      @(negedge clk);
    end
    in_valid = 0;
    repeat (4) @(negedge clk);
    pos_ok = (int'(coef_out) <= 18236 + 400);
    neg_ok = (int'(coef_out) >= 18236 - 400);
    chk(pos_ok && neg_ok, "R8 converged coefficient", coef_out, 18236);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule